// File: doc/BRIEF.md
# Address Window Decoder

This block decides where a DMA engine's address goes. It holds a small bank of programmable windows. Each window has a base word, a size-mask word and a two-bit enable field in a shared control word. The base word also carries an 8-bit target attribute, which says, for example, whether the window points at DRAM (0x0E) or at on-chip SRAM (0x1E).

A requester presents a 32-bit address. The decoder reports in the same cycle whether the address falls inside an enabled window, which window it hit, and the attribute of that window. When an address falls inside several enabled windows, the window with the lowest index wins. A miss raises a decode-error flag.

Software sets up the windows through a simple word-indexed register port. Writes take effect at the clock edge, and reads are combinational. The window count is a parameter. A typical setup uses one window per memory chip-select and places one extra window after them.

Top module: `addr_window_decoder`

## Requirements
- R1: Register index 0 is the control word, index 1+i is the base word of window i, and index 1+NUM_WIN+i is the mask word of window i. A read returns exactly the last 32-bit value written to that index. Indices at or above 2*NUM_WIN+1 read as zero, and writes to them change no register.
- R2: After reset every register reads zero, so every window is disabled and every address misses.
- R3: Window i is enabled only when control bits 16+2*i and 17+2*i are both 1. With only one of the two bits set, the window stays disabled.
- R4: An enabled window i matches when (addr[31:16] & ~mask[31:16]) equals (base[31:16] & ~mask[31:16]). For example, mask 0x0FFF0000 spans 256 MB and mask 0x03FF0000 spans 64 MB.
- R5: When several enabled windows match, win_idx reports the lowest-numbered one.
- R6: On a match, hit=1, dec_err=0, win_idx is the winning window, and attr equals bits [15:8] of that window's base word.
- R7: On a miss, hit=0, dec_err=1, attr=0 and win_idx=0.
- R8: Decode is combinational from req_addr and the register contents. A register write affects decode from the cycle after its write edge.
- R9: Base bits [7:0] and mask bits [15:0] are stored but have no effect on decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | $clog2(2*NUM_WIN+1) | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| req_addr | input | 32 | Address to decode |
| hit | output | 1 | Address falls in an enabled window |
| win_idx | output | max(1,$clog2(NUM_WIN)) | Winning window index |
| attr | output | 8 | Target attribute of the winning window |
| dec_err | output | 1 | No enabled window matched |

## Verification
The assertions check properties that must hold on every cycle. hit and dec_err must always be opposites. A miss must give a zero attribute and index. The window index must stay in range. Readback must return the data written in the previous cycle, and unmapped indices must read zero. Decode outputs must hold still while neither the address nor the registers change.

Other behaviours depend on what the windows contain, so only the bench's scenarios can show them. These are the two-bit enable rule, the mask arithmetic, lowest-index priority among overlapping windows, and the fact that low base and mask bits are ignored. The bench checks them against a behavioural model on every clock and with targeted probes.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int NUM_WIN = 5,
  localparam int NREG = 2 * NUM_WIN + 1,
  localparam int AW = $clog2(NREG),
  localparam int IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [31:0]   req_addr,
  output logic          hit,
  output logic [IW-1:0] win_idx,
  output logic [7:0]    attr,
  output logic          dec_err
);

  logic [31:0] ctrl_q;
  logic [31:0] base_q [NUM_WIN];
  logic [31:0] mask_q [NUM_WIN];
  logic [NUM_WIN-1:0] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int i = 0; i < NUM_WIN; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
      end
    end else if (reg_we) begin
      if (reg_addr == '0) ctrl_q <= reg_wdata;
      for (int i = 0; i < NUM_WIN; i++) begin
        if (reg_addr == AW'(1 + i))           base_q[i] <= reg_wdata;
        if (reg_addr == AW'(1 + NUM_WIN + i)) mask_q[i] <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = ctrl_q;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (reg_addr == AW'(1 + i))           reg_rdata = base_q[i];
      if (reg_addr == AW'(1 + NUM_WIN + i)) reg_rdata = mask_q[i];
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    wire en = &ctrl_q[16 + 2*g +: 2];
    wire [15:0] keep = ~mask_q[g][31:16];
    assign match[g] = en && ((req_addr[31:16] & keep) == (base_q[g][31:16] & keep));
  end

  always_comb begin
    win_idx = '0;
    attr    = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        win_idx = IW'(i);
        attr    = base_q[i][15:8];
      end
    end
  end

  assign hit     = |match;
  assign dec_err = ~hit;

endmodule

// File: rtl/addr_win_chk.sv
module addr_win_chk #(
  parameter int NUM_WIN = 5,
  localparam int NREG = 2 * NUM_WIN + 1,
  localparam int AW = $clog2(NREG),
  localparam int IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic [31:0]   req_addr,
  input logic          hit,
  input logic [IW-1:0] win_idx,
  input logic [7:0]    attr,
  input logic          dec_err
);

  a_r6_hit_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    hit != dec_err);

  a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dec_err |-> (attr == 8'h00 && win_idx == '0));

  a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (int'(win_idx) < NUM_WIN));

  a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && int'(reg_addr) < NREG) |=>
      ((reg_addr != $past(reg_addr)) || (reg_rdata == $past(reg_wdata))));

  a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) >= NREG) |-> (reg_rdata == 32'h0));

  a_r8_decode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_we) && $stable(req_addr)) |->
      ($stable(hit) && $stable(win_idx) && $stable(attr)));

endmodule

bind addr_window_decoder addr_win_chk #(.NUM_WIN(NUM_WIN)) u_chk (.*);

// File: tb/addr_window_decoder_test.sv
`timescale 1ns/1ps
module addr_window_decoder_test;
  localparam int N = 5;
  localparam int NREG = 2 * N + 1;
  localparam int AW = $clog2(NREG);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, req_addr = '0;
  logic [31:0] reg_rdata;
  logic hit, dec_err;
  logic [IW-1:0] win_idx;
  logic [7:0] attr;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] mref [NREG];

  addr_window_decoder #(.NUM_WIN(N)) uut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mref[i] <= 32'h0;
    end else if (reg_we && int'(reg_addr) < NREG) begin
      mref[reg_addr] <= reg_wdata;
    end
  end

  task automatic model(input logic [31:0] a, output bit h, output int idx, output logic [7:0] at);
    h = 0; idx = 0; at = 8'h00;
    for (int i = 0; i < N; i++) begin
      logic [15:0] keep;
      keep = ~mref[1 + N + i][31:16];
      if (!h && mref[0][16 + 2*i] && mref[0][17 + 2*i] &&
          ((a[31:16] & keep) == (mref[1 + i][31:16] & keep))) begin
        h = 1; idx = i; at = mref[1 + i][15:8];
      end
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit eh; int ei; logic [7:0] ea; logic [31:0] er;
      model(req_addr, eh, ei, ea);
      er = (int'(reg_addr) < NREG) ? mref[reg_addr] : 32'h0;
      checks++;
      if (hit !== eh || dec_err !== !eh || int'(win_idx) != ei || attr !== ea || reg_rdata !== er) begin
        fails++;
        $display("FAIL R8 cycle model: actual hit=%b idx=%0d attr=%h rdata=%h expected hit=%b idx=%0d attr=%h rdata=%h",
                 hit, win_idx, attr, reg_rdata, eh, ei, ea, er);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rdchk(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = AW'(a);
    #1.5;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s read idx %0d: actual %h expected %h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic probe(input logic [31:0] a, input bit eh, input int ei, input logic [7:0] ea, input string tag);
    @(negedge clk);
    req_addr = a;
    #1.5;
    checks++;
    if (hit !== eh || dec_err !== !eh || int'(win_idx) != ei || attr !== ea) begin
      fails++;
      $display("FAIL %s addr %h: actual hit=%b err=%b idx=%0d attr=%h expected hit=%b idx=%0d attr=%h",
               tag, a, hit, dec_err, win_idx, attr, eh, ei, ea);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL R8 watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NREG; i++) rdchk(i, 32'h0, "R2");
    probe(32'h0000_0000, 0, 0, 8'h00, "R2");
    probe(32'h4000_0000, 0, 0, 8'h00, "R2");

    wr(1, 32'h0000_0EA5);
    wr(1 + N, 32'h0FFF_FFFF);
    rdchk(1, 32'h0000_0EA5, "R1");
    rdchk(1 + N, 32'h0FFF_FFFF, "R1");
    probe(32'h0ABC_1234, 0, 0, 8'h00, "R3");
    wr(0, 32'h0001_0000);
    probe(32'h0ABC_1234, 0, 0, 8'h00, "R3");
    wr(0, 32'h0002_0000);
    probe(32'h0ABC_1234, 0, 0, 8'h00, "R3");
    wr(0, 32'h0003_0000);
    probe(32'h0ABC_1234, 1, 0, 8'h0E, "R6");
    probe(32'h0FFF_FFFF, 1, 0, 8'h0E, "R9");
    probe(32'h1000_0000, 0, 0, 8'h00, "R7");

    wr(5, 32'h4000_1E00);
    wr(5 + N, 32'h03FF_0000);
    wr(0, 32'h0303_0000);
    probe(32'h43FF_FFFF, 1, 4, 8'h1E, "R4");
    probe(32'h4000_0000, 1, 4, 8'h1E, "R4");
    probe(32'h4400_0000, 0, 0, 8'h00, "R4");
    probe(32'h3FFF_FFFF, 0, 0, 8'h00, "R7");

    wr(2, 32'h0000_2200);
    wr(2 + N, 32'h1FFF_0000);
    wr(0, 32'h030F_0000);
    probe(32'h0100_0000, 1, 0, 8'h0E, "R5");
    probe(32'h1800_0000, 1, 1, 8'h22, "R5");

    wr(15, 32'hDEAD_BEEF);
    rdchk(15, 32'h0, "R1");
    rdchk(0, 32'h030F_0000, "R1");
    rdchk(2, 32'h0000_2200, "R1");

    wr(2, 32'h2000_3300);
    probe(32'h1800_0000, 0, 0, 8'h00, "R8");
    probe(32'h2345_0000, 1, 1, 8'h33, "R8");

    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      req_addr = $urandom;
      reg_addr = AW'($urandom_range(0, 15));
      if (k % 40 == 0) begin
        reg_we = 1; reg_wdata = $urandom;
        if (int'(reg_addr) == 0) reg_wdata[31:16] = $urandom | 16'h5555;
        @(negedge clk);
        reg_we = 0;
      end
    end

    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule